// File: doc/BRIEF.md
# Shared Two-Dimensional Parameter Slot Allocator

A DMA controller with many channels often has only a few register sets that describe a two-dimensional transfer: a row length X, a row count Y and a line stride W. This block decides which channel may use which set. A channel asks for a slot by presenting its X, Y and W. It receives a slot that is either unused or already programmed with exactly the same three values. Channels with identical geometry therefore share one slot through a per-slot user count. A channel that needs different geometry competes for a remaining slot.

When a channel's transfer finishes, the controller releases that channel. The slot's user count drops, and the channel's record is cleared. The block keeps a per-channel record of whether the channel holds a slot and which one. A request that finds no compatible slot gets a busy response and changes nothing.

Requests and releases are each taken one per cycle. Each update of the shared state happens in a single clock edge, so no software-style locking is needed around it. When a request and a release arrive in the same cycle, the release is applied first. The request therefore sees the slot state the release leaves behind. The allocator does no address generation and holds no descriptor queues.

Top module: `slot2d_alloc`

## Requirements
- R1: After reset, every slot user count in `slot_cnt` is zero, no bit of `ch_held` is set and `gnt_valid` is low.
- R2: Every cycle with `req_valid` high is answered by exactly one cycle of `gnt_valid` high on the following cycle. `gnt_valid` is low after a cycle without a request.
- R3: A slot is eligible when its user count is zero, or when its stored X, Y and W all equal the requested values. The lowest-numbered eligible slot is granted. `gnt_slot` gives the slot index (0 is the first slot, 1 the second), and `gnt_busy` is low on a grant.
- R4: On a grant, the slot stores the requested X, Y and W and its user count rises by one. The requesting channel's bit in `ch_held` is set, and its field `ch_slot[ch*SLOT_W +: SLOT_W]` holds the slot index. Slot s's count is `slot_cnt[s*CNT_W +: CNT_W]`.
- R5: If no slot is eligible, the response has `gnt_busy` high and `gnt_slot` zero. No slot count and no channel record changes.
- R6: A release for a channel whose `ch_held` bit is set lowers that channel's slot count by one and clears the bit.
- R7: A release for a channel whose `ch_held` bit is clear is ignored. No count and no record changes.
- R8: When a release and a request occur in the same cycle, eligibility is judged on the state after the release. A slot that the release empties may be granted with new parameters.
- R9: A request from a channel that still holds a slot is answered busy and changes nothing. This check is made after any same-cycle release of that channel.
- R10: The sum of all slot user counts always equals the number of set bits in `ch_held`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Slot request strobe |
| req_ch | input | 4 | Requesting channel |
| req_x | input | 16 | Requested row length |
| req_y | input | 16 | Requested row count |
| req_w | input | 16 | Requested line stride |
| rel_valid | input | 1 | Release strobe (transfer complete) |
| rel_ch | input | 4 | Releasing channel |
| gnt_valid | output | 1 | Response valid, one cycle after a request |
| gnt_busy | output | 1 | No compatible slot, or requester already holds one |
| gnt_slot | output | 1 | Granted slot index |
| ch_held | output | 16 | Per-channel slot-held flags |
| ch_slot | output | 16 | Per-channel slot index fields |
| slot_cnt | output | 10 | Per-slot user counts |

## Verification
The hardest case to reach is a release that empties a slot in the same cycle as a request with different geometry. In that case the request must take the freed slot instead of getting a busy response. The stimulus builds this deliberately: it fills both slots with different parameters, then issues the release of a slot's last user together with a conflicting request. A long pseudo-random sweep follows. It draws channels and geometry from a very small value set so that matches, conflicts, double requests and same-cycle release/request pairs all recur many times. A bench model built from the requirements predicts every response, count and channel record.

// File: rtl/slot2d_pkg.sv
package slot2d_pkg;

    localparam int DIM_W = 16;

    typedef struct packed {
        logic [DIM_W-1:0] x;
        logic [DIM_W-1:0] y;
        logic [DIM_W-1:0] w;
    } dims_t;

    function automatic logic same_dims(input dims_t a, input dims_t b);
        return (a.x == b.x) && (a.y == b.y) && (a.w == b.w);
    endfunction

endpackage

// File: rtl/slot2d_pick.sv
module slot2d_pick #(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic [N-1:0]  elig,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) idx = IW'(i);
        end
    end
    assign any = |elig;
endmodule

// File: rtl/slot2d_bank.sv
module slot2d_bank
    import slot2d_pkg::*;
#(
    parameter int SLOTS  = 2,
    parameter int SLOT_W = 1,
    parameter int CNT_W  = 5,
    parameter int MAXCNT = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          inc_en,
    input  logic [SLOT_W-1:0]             inc_idx,
    input  dims_t                         inc_dims,
    input  logic                          dec_en,
    input  logic [SLOT_W-1:0]             dec_idx,
    output logic [SLOTS-1:0][CNT_W-1:0]   cnt_o,
    output dims_t [SLOTS-1:0]             dims_o
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic up, dn;
        assign up = inc_en && (inc_idx == SLOT_W'(s));
        assign dn = dec_en && (dec_idx == SLOT_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_o[s]  <= '0;
                dims_o[s] <= '0;
            end else begin
                if (up && !dn)      cnt_o[s] <= cnt_o[s] + 1'b1;
                else if (dn && !up) cnt_o[s] <= cnt_o[s] - 1'b1;
                if (up) dims_o[s] <= inc_dims;
            end
        end

        p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
            dn |-> (cnt_o[s] != '0));
        p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
            cnt_o[s] <= CNT_W'(MAXCNT));
        p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
            (cnt_o[s] != $past(cnt_o[s])) |->
            ((cnt_o[s] == $past(cnt_o[s]) + 1'b1) || (cnt_o[s] == $past(cnt_o[s]) - 1'b1)));
    end
endmodule

// File: rtl/slot2d_chtab.sv
module slot2d_chtab #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4,
    parameter int SLOT_W = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           set_en,
    input  logic [CH_W-1:0]                set_ch,
    input  logic [SLOT_W-1:0]              set_slot,
    input  logic                           clr_en,
    input  logic [CH_W-1:0]                clr_ch,
    output logic [NUM_CH-1:0]              held_o,
    output logic [NUM_CH-1:0][SLOT_W-1:0]  slot_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                held_o[c] <= 1'b0;
                slot_o[c] <= '0;
            end else if (set_en && (set_ch == CH_W'(c))) begin
                held_o[c] <= 1'b1;
                slot_o[c] <= set_slot;
            end else if (clr_en && (clr_ch == CH_W'(c))) begin
                held_o[c] <= 1'b0;
            end
        end
    end

    p_set_only_free_r9: assert property (@(posedge clk) disable iff (rst)
        set_en |-> (!held_o[set_ch] || (clr_en && (clr_ch == set_ch))));
    p_clear_only_held_r7: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> held_o[clr_ch]);
endmodule

// File: rtl/slot2d_alloc.sv
module slot2d_alloc
    import slot2d_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int SLOTS  = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(NUM_CH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [CH_W-1:0]            req_ch,
    input  logic [DIM_W-1:0]           req_x,
    input  logic [DIM_W-1:0]           req_y,
    input  logic [DIM_W-1:0]           req_w,
    input  logic                       rel_valid,
    input  logic [CH_W-1:0]            rel_ch,
    output logic                       gnt_valid,
    output logic                       gnt_busy,
    output logic [SLOT_W-1:0]          gnt_slot,
    output logic [NUM_CH-1:0]          ch_held,
    output logic [NUM_CH*SLOT_W-1:0]   ch_slot,
    output logic [SLOTS*CNT_W-1:0]     slot_cnt
);
    logic [NUM_CH-1:0]              held;
    logic [NUM_CH-1:0][SLOT_W-1:0]  slot_of;
    logic [SLOTS-1:0][CNT_W-1:0]    cnt;
    dims_t [SLOTS-1:0]              dims;
    dims_t                          req_d;
    logic                           rel_eff;
    logic [SLOT_W-1:0]              rel_slot;
    logic [SLOTS-1:0]               elig;
    logic                           pick_any;
    logic [SLOT_W-1:0]              pick_idx;
    logic                           holder_busy;
    logic                           grant;

    assign req_d    = '{x: req_x, y: req_y, w: req_w};
    assign rel_eff  = rel_valid && held[rel_ch];
    assign rel_slot = slot_of[rel_ch];

    // Eligibility is judged on the counts the release leaves behind.
    for (genvar s = 0; s < SLOTS; s++) begin : g_elig
        logic [CNT_W-1:0] cnt_after;
        assign cnt_after = cnt[s] - CNT_W'(rel_eff && (rel_slot == SLOT_W'(s)));
        assign elig[s]   = (cnt_after == '0) || same_dims(dims[s], req_d);
    end

    slot2d_pick #(.N(SLOTS), .IW(SLOT_W)) pick_i (
        .elig (elig),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    assign holder_busy = held[req_ch] && !(rel_eff && (rel_ch == req_ch));
    assign grant       = req_valid && pick_any && !holder_busy;

    slot2d_bank #(
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .MAXCNT(NUM_CH)
    ) bank_i (
        .clk      (clk),
        .rst      (rst),
        .inc_en   (grant),
        .inc_idx  (pick_idx),
        .inc_dims (req_d),
        .dec_en   (rel_eff),
        .dec_idx  (rel_slot),
        .cnt_o    (cnt),
        .dims_o   (dims)
    );

    slot2d_chtab #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SLOT_W(SLOT_W)) chtab_i (
        .clk      (clk),
        .rst      (rst),
        .set_en   (grant),
        .set_ch   (req_ch),
        .set_slot (pick_idx),
        .clr_en   (rel_eff),
        .clr_ch   (rel_ch),
        .held_o   (held),
        .slot_o   (slot_of)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid <= 1'b0;
            gnt_busy  <= 1'b0;
            gnt_slot  <= '0;
        end else begin
            gnt_valid <= req_valid;
            gnt_busy  <= req_valid && !grant;
            gnt_slot  <= grant ? pick_idx : '0;
        end
    end

    assign ch_held  = held;
    assign ch_slot  = slot_of;
    assign slot_cnt = cnt;

    // Checking aid: total users across slots.
    int total_users;
    always_comb begin
        total_users = 0;
        for (int s = 0; s < SLOTS; s++) total_users += int'(cnt[s]);
    end

    p_users_match_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(held) == total_users);
    p_one_resp_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> gnt_valid);
    p_grant_dims_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid ##1 (gnt_valid && !gnt_busy) |->
        same_dims(dims[gnt_slot], $past(req_d)));
    p_busy_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid && !rel_valid ##1 gnt_busy |->
        ($stable(cnt) && $stable(held)));
endmodule

// File: tb/slot2d_alloc_tb_top.sv
module slot2d_alloc_tb_top;
    localparam int NCH = 16;
    localparam int NS  = 2;
    localparam int CW  = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_ch = '0;
    logic [15:0] req_x = '0, req_y = '0, req_w = '0;
    logic        rel_valid = 1'b0;
    logic [3:0]  rel_ch = '0;
    logic        gnt_valid, gnt_busy;
    logic [0:0]  gnt_slot;
    logic [15:0] ch_held;
    logic [15:0] ch_slot;
    logic [9:0]  slot_cnt;

    always #4 clk = ~clk;

    slot2d_alloc dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ch(req_ch),
        .req_x(req_x), .req_y(req_y), .req_w(req_w),
        .rel_valid(rel_valid), .rel_ch(rel_ch),
        .gnt_valid(gnt_valid), .gnt_busy(gnt_busy), .gnt_slot(gnt_slot),
        .ch_held(ch_held), .ch_slot(ch_slot), .slot_cnt(slot_cnt)
    );

    int n_chk = 0, n_bad = 0;
    int m_cnt [NS];
    int m_x [NS], m_y [NS], m_w [NS];
    bit m_held [NCH];
    int m_slot [NCH];
    bit last_busy;
    int last_slot;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_state();
        int tot = 0, hc = 0;
        for (int s = 0; s < NS; s++) begin
            chk("R4 count", int'(slot_cnt[s*CW +: CW]), m_cnt[s]);
            tot += int'(slot_cnt[s*CW +: CW]);
        end
        for (int c = 0; c < NCH; c++) begin
            chk("R6 held", int'(ch_held[c]), int'(m_held[c]));
            if (m_held[c]) chk("R4 slot index", int'(ch_slot[c]), m_slot[c]);
            hc += int'(ch_held[c]);
        end
        chk("R10 sum", tot, hc);
    endtask

    task automatic step(bit qv, int qc, int x, int y, int w, bit rv, int rc);
        bit rel_eff, hb, found;
        int after [NS];
        int pk;
        rel_eff = rv && m_held[rc];
        for (int s = 0; s < NS; s++) after[s] = m_cnt[s];
        if (rel_eff) after[m_slot[rc]]--;
        hb = m_held[qc] && !(rel_eff && rc == qc);
        found = 1'b0; pk = 0;
        for (int s = NS - 1; s >= 0; s--)
            if (after[s] == 0 || (m_x[s] == x && m_y[s] == y && m_w[s] == w)) begin
                found = 1'b1; pk = s;
            end
        for (int s = 0; s < NS; s++) m_cnt[s] = after[s];
        if (rel_eff) m_held[rc] = 1'b0;
        last_busy = qv && !(found && !hb);
        last_slot = 0;
        if (qv && found && !hb) begin
            m_cnt[pk]++; m_x[pk] = x; m_y[pk] = y; m_w[pk] = w;
            m_held[qc] = 1'b1; m_slot[qc] = pk; last_slot = pk;
        end
        req_valid = qv; req_ch = 4'(qc);
        req_x = 16'(x); req_y = 16'(y); req_w = 16'(w);
        rel_valid = rv; rel_ch = 4'(rc);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; rel_valid = 1'b0;
        chk("R2 valid", int'(gnt_valid), int'(qv));
        if (qv) begin
            chk("R3 busy", int'(gnt_busy), int'(last_busy));
            chk("R3 slot", int'(gnt_slot), last_slot);
        end
        compare_state();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        bit [31:0] r = 32'h1234_5678;
        for (int s = 0; s < NS; s++) begin m_cnt[s] = 0; m_x[s] = 0; m_y[s] = 0; m_w[s] = 0; end
        for (int c = 0; c < NCH; c++) begin m_held[c] = 0; m_slot[c] = 0; end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 counts", int'(slot_cnt), 0);
        chk("R1 held", int'(ch_held), 0);
        chk("R1 valid", int'(gnt_valid), 0);

        step(1, 0, 10, 20, 30, 0, 0);      // first slot
        chk("R3 first slot", int'(gnt_slot), 0);
        step(1, 1, 10, 20, 30, 0, 0);      // shares slot 0
        chk("R3 share", int'(slot_cnt[4:0]), 2);
        step(1, 2, 40, 50, 60, 0, 0);      // takes slot 1
        chk("R3 second slot", int'(gnt_slot), 1);
        step(1, 3, 7, 7, 7, 0, 0);         // conflict
        chk("R5 busy", int'(gnt_busy), 1);
        step(0, 0, 0, 0, 0, 1, 9);         // release of idle channel
        chk("R7 ignored", int'(slot_cnt), (1 << CW) | 2);
        step(1, 0, 10, 20, 30, 0, 0);      // double request
        chk("R9 holder busy", int'(gnt_busy), 1);
        step(1, 3, 7, 7, 7, 1, 2);         // release frees slot 1 in same cycle
        chk("R8 same cycle", int'(gnt_busy), 0);
        chk("R8 slot", int'(gnt_slot), 1);
        step(1, 0, 1, 1, 1, 1, 0);         // self release then re-request
        chk("R9 self release", int'(gnt_busy), 1);
        step(0, 0, 0, 0, 0, 1, 3);
        chk("R6 release", int'(slot_cnt[9:5]), 0);

        for (int i = 0; i < 4000; i++) begin
            bit qv, rv;
            int qc, rc, x, y;
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            qv = r[0] | r[1];
            rv = r[2];
            qc = int'(r[7:4]);
            rc = int'(r[11:8]);
            x  = int'(r[12]);
            y  = int'(r[13] & r[14]);
            step(qv, qc, x, y, 3, rv, rc);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule